// File: doc/BRIEF.md
# Presettable Ratio Clock Divider

This block sits on a single fast clock and derives from it four slower timing references: square waves at one half, one quarter, one eighth and one sixteenth of the input rate. Each is paired with a single-cycle enable strobe. Downstream logic that stays in the fast clock domain can use these strobes instead of a real divided clock. One low-speed output clock is also produced. Three static select inputs choose its ratio (divide by 4, 8 or 16) and its polarity.

All four ratios come from one 4-bit binary up-counter, so their edges are aligned by construction. A synchronous active-high preset input holds the counter at zero. When several converter lanes release preset on the same fast-clock edge, their divided clocks run in phase. The output clock is re-timed through a flop on the fast clock, so it carries no decode glitches.

Top module: `ratio_clock_divider`

## Requirements
- R1: While `rst_n` is low, `div_phase`, `div_stb` and `clk_out` are all 0.
- R2: A clock edge that samples `preset` high leaves the counter at zero. After that edge, `div_phase` and `div_stb` are all 0 for as long as preset stays high.
- R3: On each edge that samples `preset` low, the counter advances by one, modulo 16. The first edge after preset is released moves `div_phase` from 0 to 1.
- R4: `div_phase[n]` is bit n of the counter. It is a 50% duty square wave with a period of 2^(n+1) fast cycles: divide by 2, 4, 8 and 16 for n = 0..3.
- R5: `div_stb[n]` is high in exactly those cycles where `div_phase[n:0]` are all ones, once per 2^(n+1) cycles. The next edge without preset then clears `div_phase[n]`.
- R6: With `sel_fast`=1 and `sel_mid`=1, `clk_out` follows `div_phase[1]` (divide by 4), XORed with `sel_inv`.
- R7: With `sel_fast`=0 and `sel_mid`=1, `clk_out` follows `div_phase[2]` (divide by 8), XORed with `sel_inv`.
- R8: With `sel_mid`=0, `clk_out` follows `div_phase[3]` (divide by 16) whatever `sel_fast` holds, XORed with `sel_inv`.
- R9: `sel_inv`=1 gives the complement of the selected phase and `sel_inv`=0 passes it unchanged. While preset holds the counter at zero, `clk_out` equals `sel_inv`.
- R10: `clk_out` is a flop output. Each edge sets it from the selects sampled at that edge and the counter value that edge produces, so it lines up with `div_phase` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset | input | 1 | Synchronous active-high counter preset for phase alignment |
| sel_fast | input | 1 | Chooses divide by 4 (1) or 8 (0) when sel_mid is 1 |
| sel_mid | input | 1 | 0 forces the divide-by-16 output choice |
| sel_inv | input | 1 | 1 inverts the output clock |
| div_phase | output | 4 | Divided square waves, bit n = divide by 2^(n+1) |
| div_stb | output | 4 | One-cycle enable per ratio |
| clk_out | output | 1 | Selected, optionally inverted output clock |

## Verification
The bench goes after the counter wrap from 15 to 0. A strobe decoded from the wrong bit range would fire at the wrong place or twice per period. It holds preset for several cycles and then releases it. An off-by-one there would show `div_phase` starting at 0 or 2 instead of 1, which would leave parallel lanes out of phase.

It runs `sel_mid`=0 with both values of `sel_fast`. A decoder that ignored the override would emit divide by 4 or 8 in that case. It also changes the selects mid-run. An output that lagged by a cycle, or was decoded from the old count, would be off by one edge against `div_phase`.

// File: rtl/ratio_clock_divider_pkg.sv
package ratio_clock_divider_pkg;

  // Output-clock ratio choices. Only the three slowest phases can be routed out.
  typedef enum logic [1:0] {
    TAP_DIV4  = 2'd0,
    TAP_DIV8  = 2'd1,
    TAP_DIV16 = 2'd2
  } tap_e;

  // sel_mid low overrides sel_fast and picks divide by 16.
  function automatic tap_e decode_tap(input logic fast, input logic mid);
    tap_e t;
    if (!mid)      t = TAP_DIV16;
    else if (fast) t = TAP_DIV4;
    else           t = TAP_DIV8;
    return t;
  endfunction

  // Counter bit carrying the chosen ratio: bit n divides by 2^(n+1).
  function automatic logic [1:0] tap_bit(input tap_e t);
    logic [1:0] b;
    case (t)
      TAP_DIV4:  b = 2'd1;
      TAP_DIV8:  b = 2'd2;
      default:   b = 2'd3;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/div_counter.sv
module div_counter #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset,
  output logic [STAGES-1:0] cnt_q,
  output logic [STAGES-1:0] cnt_next
);

  localparam logic [STAGES-1:0] ONE = STAGES'(1);

  always_comb begin
    if (preset) cnt_next = '0;
    else        cnt_next = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next;
  end

endmodule

// File: rtl/div_strobe_gen.sv
module div_strobe_gen #(
  parameter int STAGES = 4
) (
  input  logic [STAGES-1:0] cnt_q,
  output logic [STAGES-1:0] stb
);

  // Ratio n fires when every counter bit up to and including n is set.
  for (genvar n = 0; n < STAGES; n++) begin : g_stb
    assign stb[n] = &cnt_q[n:0];
  end

endmodule

// File: rtl/div_out_sel.sv
module div_out_sel
  import ratio_clock_divider_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] cnt_next,
  input  logic              sel_fast,
  input  logic              sel_mid,
  input  logic              sel_inv,
  output logic              clk_out
);

  tap_e       tap;
  logic [1:0] tap_idx;
  logic       tap_val;

  always_comb begin
    tap     = decode_tap(sel_fast, sel_mid);
    tap_idx = tap_bit(tap);
    tap_val = cnt_next[tap_idx] ^ sel_inv;
  end

  // Re-time on the fast clock so the mux and inverter cannot glitch the output.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_out <= 1'b0;
    else        clk_out <= tap_val;
  end

endmodule

// File: rtl/ratio_clock_divider.sv
module ratio_clock_divider #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset,
  input  logic              sel_fast,
  input  logic              sel_mid,
  input  logic              sel_inv,
  output logic [STAGES-1:0] div_phase,
  output logic [STAGES-1:0] div_stb,
  output logic              clk_out
);

  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] cnt_next;
  logic              count_wrap;

  div_counter #(.STAGES(STAGES)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .preset   (preset),
    .cnt_q    (cnt_q),
    .cnt_next (cnt_next)
  );

  div_strobe_gen #(.STAGES(STAGES)) u_strobe (
    .cnt_q (cnt_q),
    .stb   (div_stb)
  );

  div_out_sel #(.STAGES(STAGES)) u_out_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_next (cnt_next),
    .sel_fast (sel_fast),
    .sel_mid  (sel_mid),
    .sel_inv  (sel_inv),
    .clk_out  (clk_out)
  );

  assign div_phase  = cnt_q;
  assign count_wrap = div_stb[STAGES-1];

endmodule

// File: rtl/ratio_clock_divider_chk.sv
module ratio_clock_divider_chk #(
  parameter int STAGES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              preset,
  input logic              sel_fast,
  input logic              sel_mid,
  input logic              sel_inv,
  input logic [STAGES-1:0] div_phase,
  input logic [STAGES-1:0] div_stb,
  input logic              clk_out,
  input logic              count_wrap
);

  // R2
  p_preset_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (div_phase == '0) && (div_stb == '0));

  // R3
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !preset |=> div_phase == STAGES'($past(div_phase) + STAGES'(1)));

  // R4
  p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_wrap && !preset) |=> (div_phase == '0));

  for (genvar n = 0; n < STAGES; n++) begin : g_stb_chk
    // R5
    p_stb_then_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (div_stb[n] && !preset) |=> $fell(div_phase[n]));
  end

  for (genvar n = 1; n < STAGES; n++) begin : g_nest_chk
    // R5
    p_stb_nested_r5: assert property (@(posedge clk) disable iff (!rst_n)
      div_stb[n] |-> div_stb[n-1]);
  end

  // R6
  p_out_div4_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mid && sel_fast) |=> (clk_out == (div_phase[1] ^ $past(sel_inv))));

  // R7
  p_out_div8_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mid && !sel_fast) |=> (clk_out == (div_phase[2] ^ $past(sel_inv))));

  // R8
  p_out_div16_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_mid |=> (clk_out == (div_phase[3] ^ $past(sel_inv))));

  // R9
  p_preset_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (clk_out == $past(sel_inv)));

endmodule

bind ratio_clock_divider ratio_clock_divider_chk #(.STAGES(STAGES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .preset     (preset),
  .sel_fast   (sel_fast),
  .sel_mid    (sel_mid),
  .sel_inv    (sel_inv),
  .div_phase  (div_phase),
  .div_stb    (div_stb),
  .clk_out    (clk_out),
  .count_wrap (count_wrap)
);

// File: tb/ratio_clock_divider_bench.sv
module ratio_clock_divider_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       preset = 1'b0;
  logic       sel_fast = 1'b1;
  logic       sel_mid = 1'b1;
  logic       sel_inv = 1'b0;
  logic [3:0] div_phase;
  logic [3:0] div_stb;
  logic       clk_out;

  int tests = 0;
  int fails = 0;
  int m_cnt = 0;

  typedef struct {
    logic [3:0] ph;
    logic [3:0] stb;
    logic       ck;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  ratio_clock_divider u_ratio_clock_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .preset    (preset),
    .sel_fast  (sel_fast),
    .sel_mid   (sel_mid),
    .sel_inv   (sel_inv),
    .div_phase (div_phase),
    .div_stb   (div_stb),
    .clk_out   (clk_out)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of inputs and pushes the expected post-edge outputs.
  task automatic step(input logic pre, input logic s_fast, input logic s_mid,
                      input logic s_inv, input string tag);
    exp_t e;
    int   ratio;
    @(negedge clk);
    preset = pre; sel_fast = s_fast; sel_mid = s_mid; sel_inv = s_inv;
    m_cnt = pre ? 0 : (m_cnt + 1) % 16;
    for (int n = 0; n < 4; n++)
      e.stb[n] = (((m_cnt + 1) % (2 << n)) == 0);
    e.ph  = 4'(m_cnt);
    ratio = s_mid ? (s_fast ? 4 : 8) : 16;
    e.ck  = 1'(((m_cnt / (ratio / 2)) % 2) != 0) ^ s_inv;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares after each edge, away from the edge itself.
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, "div_phase", int'(div_phase), int'(e.ph));
      check(e.tag, "div_stb",   int'(div_stb),   int'(e.stb));
      check(e.tag, "clk_out",   int'(clk_out),   int'(e.ck));
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    preset = 1'b1;
    #20;
    // R1: outputs quiet under reset
    check("R1", "div_phase", int'(div_phase), 0);
    check("R1", "div_stb",   int'(div_stb),   0);
    check("R1", "clk_out",   int'(clk_out),   0);
    @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0;

    // R4 R5 R6: free run across two wraps, divide by 4
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 1'b1, 1'b0, "R4_R5_R6");
    // R2: preset hold
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R2");
    // R3: release, first count is 1
    step(1'b0, 1'b1, 1'b1, 1'b0, "R3");
    // R7: divide by 8
    for (int i = 0; i < 32; i++) step(1'b0, 1'b0, 1'b1, 1'b0, "R7");
    // R8: divide by 16, sel_fast ignored either way
    for (int i = 0; i < 32; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R8");
    for (int i = 0; i < 32; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R8");
    // R9: inverted output, then preset with inversion on
    for (int i = 0; i < 24; i++) step(1'b0, 1'b1, 1'b1, 1'b1, "R9");
    for (int i = 0; i < 2; i++)  step(1'b1, 1'b0, 1'b0, 1'b1, "R9");
    // R10: select changes mid-run take effect on the same edge
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 1'b1, 1'b1, 1'b0, "R10");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R10");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R10");
    end
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule